// File: doc/BRIEF.md
# Zero-Overhead Loop Program Sequencer

This block produces the program memory fetch address for a small signal-processing core, one new address per clock. The decoder in front of it presents the decoded fields of the instruction that sits at the current fetch address: an operation type, a condition code, a branch or loop-end target and a loop count. The core's status flags come in alongside. From these the sequencer picks the next address. It can step to the next address, take a conditional jump, enter a subroutine, return from one, or open a hardware loop. None of these choices costs an extra cycle.

Hardware loops need no closing jump. When a loop is opened, the sequencer saves the address of the first body instruction on the return-address stack. It saves the last body address and the exit condition on a loop stack. A counted loop also saves its count on a counter stack. On every cycle the fetch address is compared with the innermost saved last address. When they match, the sequencer branches back to the saved start, or it falls out of the loop and releases the loop's entries on all three stacks. Loops can be nested. A push onto a full stack and a pop from an empty stack are recorded in sticky error flags.

Top module: `lseq_top`

## Requirements
- R1: After synchronous reset, the fetch address is 0 and both the overflow flag and the underflow flag are 0.
- R2: Operation code 0 (step), and codes 5 to 7, give a next address of fetch address + 1, wrapping modulo 2^14, unless the loop-end rule of R7 to R9 applies.
- R3: Condition codes are: 0 always true; 1 zero flag set; 2 zero flag clear; 3 negative flag set; 4 both flags clear; 5 negative flag clear; 6 never true; 7 is the counter code, which is false for branches. With operation code 1 (jump), a true condition gives the target as the next address, and a false one gives fetch address + 1.
- R4: Operation code 2 (call) with a true condition pushes fetch address + 1 onto the 16-entry return stack and goes to the target. With a false condition it pushes nothing and goes to fetch address + 1.
- R5: Operation code 3 (return) with a true condition pops the return stack and goes to the popped address. If the stack is empty, it goes to fetch address + 1 and sets the sticky underflow flag.
- R6: Operation code 4 (loop) pushes fetch address + 1 (the loop start) onto the return stack and pushes the target (the last body address) with the condition code as the exit rule onto the 4-entry loop stack. With condition code 7 it also pushes the count onto the 4-entry counter stack. The next address is fetch address + 1.
- R7: When the fetch address equals the innermost loop's last address and the loop does not exit, the next address is the loop start. For a counted loop the top counter decrements.
- R8: A counted loop with count N of at least 1 runs its body N times. The exit happens at the last address when the top counter equals 1. It pops the return, loop and counter stacks and goes to fetch address + 1.
- R9: A loop whose exit rule is condition code 0 to 6 exits at its last address when that condition is true on the current flags, with the same pops (no counter) and next address as R8.
- R10: Nested loops run independently. The inner loop completes all its passes on each pass of the outer loop.
- R11: A taken jump, call or return at a loop's last address takes priority over the loop-back. The loop stacks are left untouched.
- R12: A push onto a full stack is dropped and sets the sticky overflow flag. This applies to the 16-entry return stack and to the 4-entry loop and counter stacks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Decoded operation of the instruction at the fetch address |
| cond_i | input | 3 | Condition code, or the loop exit rule for a loop operation |
| target_i | input | 14 | Branch target, or last body address for a loop |
| count_i | input | 14 | Loop count for counted loops |
| flag_zero_i | input | 1 | Zero status flag |
| flag_neg_i | input | 1 | Negative status flag |
| fetch_addr_o | output | 14 | Current program memory fetch address |
| stk_ovf_o | output | 1 | Sticky stack-overflow flag |
| stk_unf_o | output | 1 | Sticky stack-underflow flag |

## Verification
The hardest situations to reach from the ports are the counter reaching 1 at the inner last address while an outer loop is still active, and the drop of a 17th return address. Both need long, self-consistent instruction streams. The bench holds a small program table that it looks up by the current fetch address. This lets nested counted loops, condition-terminated loops and 17-deep call chains run as real programs. Visit counts and return addresses are then compared with values computed from the loop counts. A sweep over every condition code and flag pair checks the branch decisions.

// File: rtl/lseq_pkg.sv
package lseq_pkg;

    parameter int unsigned PA_W  = 14;
    parameter int unsigned CNT_W = 14;

    typedef enum logic [2:0] {
        OP_STEP = 3'd0,
        OP_JUMP = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_LOOP = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        CC_ALWAYS = 3'd0,
        CC_EQ     = 3'd1,
        CC_NE     = 3'd2,
        CC_LT     = 3'd3,
        CC_GT     = 3'd4,
        CC_GE     = 3'd5,
        CC_NEVER  = 3'd6,
        CC_COUNT  = 3'd7
    } cc_e;

    typedef struct packed {
        logic [PA_W-1:0] last;
        logic [2:0]      rule;
    } loop_ent_t;

    function automatic logic cc_test(input logic [2:0] code, input logic z, input logic n);
        logic res;
        case (code)
            3'd0:    res = 1'b1;
            3'd1:    res = z;
            3'd2:    res = !z;
            3'd3:    res = n;
            3'd4:    res = !n && !z;
            3'd5:    res = !n;
            default: res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/lseq_lifo.sv
module lseq_lifo #(
    parameter int unsigned W     = 14,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic         wr_top_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] top_o,
    output logic         empty_o,
    output logic         full_o,
    output logic         ovf_o,
    output logic         unf_o
);
    // DEPTH is a power of two, at least 2
    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam int unsigned SP_W  = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [SP_W-1:0]  sp;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] top_idx;

    assign empty_o = (sp == '0);
    assign full_o  = (sp == SP_W'(DEPTH));
    assign wr_idx  = sp[IDX_W-1:0];
    assign top_idx = sp[IDX_W-1:0] - IDX_W'(1);
    assign top_o   = empty_o ? '0 : mem[top_idx];
    assign ovf_o   = push_i && full_o;
    assign unf_o   = pop_i && empty_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
        end else if (push_i && !full_o) begin
            sp <= sp + SP_W'(1);
        end else if (pop_i && !empty_o) begin
            sp <= sp - SP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push_i && !full_o) begin
            mem[wr_idx] <= din_i;
        end else if (!pop_i && wr_top_i && !empty_o) begin
            mem[top_idx] <= din_i;
        end
    end

    // R12: a push onto a full stack leaves the depth unchanged
    p_full_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (push_i && full_o) |=> full_o);

    // R5: a pop of an empty stack keeps it empty
    p_empty_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && empty_o) |=> empty_o);

endmodule

// File: rtl/lseq_next.sv
module lseq_next
    import lseq_pkg::*;
(
    input  logic [PA_W-1:0]  pc_i,
    input  logic [2:0]       op_i,
    input  logic [2:0]       cond_i,
    input  logic [PA_W-1:0]  target_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             z_i,
    input  logic             n_i,
    input  logic [PA_W-1:0]  ret_top_i,
    input  logic             ret_empty_i,
    input  loop_ent_t        loop_top_i,
    input  logic             loop_empty_i,
    input  logic [CNT_W-1:0] cnt_top_i,
    output logic [PA_W-1:0]  next_o,
    output logic             ret_push_o,
    output logic             ret_pop_o,
    output logic [PA_W-1:0]  ret_din_o,
    output logic             loop_push_o,
    output logic             loop_pop_o,
    output loop_ent_t        loop_din_o,
    output logic             cnt_push_o,
    output logic             cnt_pop_o,
    output logic             cnt_dec_o,
    output logic [CNT_W-1:0] cnt_din_o
);
    logic [PA_W-1:0] seq;
    logic            taken;
    logic            redirected;
    logic            at_last;
    logic            counted;
    logic            done;

    assign seq     = pc_i + PA_W'(1);
    assign taken   = cc_test(cond_i, z_i, n_i);
    assign at_last = !loop_empty_i && (pc_i == loop_top_i.last);
    assign counted = (loop_top_i.rule == 3'(CC_COUNT));
    assign done    = counted ? (cnt_top_i == CNT_W'(1))
                             : cc_test(loop_top_i.rule, z_i, n_i);

    always_comb begin
        next_o      = seq;
        ret_push_o  = 1'b0;
        ret_pop_o   = 1'b0;
        ret_din_o   = seq;
        loop_push_o = 1'b0;
        loop_pop_o  = 1'b0;
        loop_din_o  = '{last: target_i, rule: cond_i};
        cnt_push_o  = 1'b0;
        cnt_pop_o   = 1'b0;
        cnt_dec_o   = 1'b0;
        cnt_din_o   = count_i;
        redirected  = 1'b0;

        case (op_i)
            3'(OP_JUMP): begin
                if (taken) begin
                    next_o     = target_i;
                    redirected = 1'b1;
                end
            end
            3'(OP_CALL): begin
                if (taken) begin
                    ret_push_o = 1'b1;
                    next_o     = target_i;
                    redirected = 1'b1;
                end
            end
            3'(OP_RET): begin
                if (taken) begin
                    ret_pop_o  = 1'b1;
                    next_o     = ret_empty_i ? seq : ret_top_i;
                    redirected = 1'b1;
                end
            end
            3'(OP_LOOP): begin
                ret_push_o  = 1'b1;
                loop_push_o = 1'b1;
                cnt_push_o  = (cond_i == 3'(CC_COUNT));
                redirected  = 1'b1;
            end
            default: ;
        endcase

        if (!redirected && at_last) begin
            if (done) begin
                ret_pop_o  = 1'b1;
                loop_pop_o = 1'b1;
                cnt_pop_o  = counted;
            end else begin
                next_o    = ret_top_i;
                cnt_dec_o = counted;
                cnt_din_o = cnt_top_i - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/lseq_top.sv
module lseq_top
    import lseq_pkg::*;
#(
    parameter int unsigned RET_DEPTH  = 16,
    parameter int unsigned LOOP_DEPTH = 4,
    parameter int unsigned CNT_DEPTH  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op_i,
    input  logic [2:0]       cond_i,
    input  logic [PA_W-1:0]  target_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             flag_zero_i,
    input  logic             flag_neg_i,
    output logic [PA_W-1:0]  fetch_addr_o,
    output logic             stk_ovf_o,
    output logic             stk_unf_o
);
    localparam int unsigned LE_W = $bits(loop_ent_t);

    logic [PA_W-1:0]  pc_q;
    logic [PA_W-1:0]  next_pc;
    logic             ovf_q, unf_q;

    logic [PA_W-1:0]  ret_top, ret_din;
    logic             ret_empty, ret_full, ret_push, ret_pop, ret_ovf, ret_unf;
    logic [LE_W-1:0]  loop_top_raw;
    loop_ent_t        loop_top, loop_din;
    logic             loop_empty, loop_full, loop_push, loop_pop, loop_ovf, loop_unf;
    logic [CNT_W-1:0] cnt_top, cnt_din;
    logic             cnt_empty, cnt_full, cnt_push, cnt_pop, cnt_dec, cnt_ovf, cnt_unf;

    assign loop_top = loop_ent_t'(loop_top_raw);

    lseq_next u_next (
        .pc_i        (pc_q),
        .op_i        (op_i),
        .cond_i      (cond_i),
        .target_i    (target_i),
        .count_i     (count_i),
        .z_i         (flag_zero_i),
        .n_i         (flag_neg_i),
        .ret_top_i   (ret_top),
        .ret_empty_i (ret_empty),
        .loop_top_i  (loop_top),
        .loop_empty_i(loop_empty),
        .cnt_top_i   (cnt_top),
        .next_o      (next_pc),
        .ret_push_o  (ret_push),
        .ret_pop_o   (ret_pop),
        .ret_din_o   (ret_din),
        .loop_push_o (loop_push),
        .loop_pop_o  (loop_pop),
        .loop_din_o  (loop_din),
        .cnt_push_o  (cnt_push),
        .cnt_pop_o   (cnt_pop),
        .cnt_dec_o   (cnt_dec),
        .cnt_din_o   (cnt_din)
    );

    lseq_lifo #(.W(PA_W), .DEPTH(RET_DEPTH)) u_ret (
        .clk(clk), .rst(rst), .push_i(ret_push), .pop_i(ret_pop), .wr_top_i(1'b0),
        .din_i(ret_din), .top_o(ret_top), .empty_o(ret_empty), .full_o(ret_full),
        .ovf_o(ret_ovf), .unf_o(ret_unf)
    );

    lseq_lifo #(.W(LE_W), .DEPTH(LOOP_DEPTH)) u_loop (
        .clk(clk), .rst(rst), .push_i(loop_push), .pop_i(loop_pop), .wr_top_i(1'b0),
        .din_i(LE_W'(loop_din)), .top_o(loop_top_raw), .empty_o(loop_empty),
        .full_o(loop_full), .ovf_o(loop_ovf), .unf_o(loop_unf)
    );

    lseq_lifo #(.W(CNT_W), .DEPTH(CNT_DEPTH)) u_cnt (
        .clk(clk), .rst(rst), .push_i(cnt_push), .pop_i(cnt_pop), .wr_top_i(cnt_dec),
        .din_i(cnt_din), .top_o(cnt_top), .empty_o(cnt_empty), .full_o(cnt_full),
        .ovf_o(cnt_ovf), .unf_o(cnt_unf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            pc_q  <= next_pc;
            ovf_q <= ovf_q | ret_ovf | loop_ovf | cnt_ovf;
            unf_q <= unf_q | ret_unf | loop_unf | cnt_unf;
        end
    end

    assign fetch_addr_o = pc_q;
    assign stk_ovf_o    = ovf_q;
    assign stk_unf_o    = unf_q;

    // R2: plain step outside any loop advances by one
    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'(OP_STEP) && loop_empty) |=> fetch_addr_o == $past(pc_q) + PA_W'(1));

    // R3: an unconditional jump lands on its target
    p_jump_r3: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'(OP_JUMP) && cond_i == 3'(CC_ALWAYS)) |=> fetch_addr_o == $past(target_i));

    // R4: a taken call leaves the return address on the stack top
    p_call_push_r4: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'(OP_CALL) && cond_i == 3'(CC_ALWAYS) && !ret_full)
        |=> ret_top == $past(pc_q) + PA_W'(1));

    // R7: a never-exiting loop at its last address returns to its start
    p_loop_back_r7: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'(OP_STEP) && !loop_empty && pc_q == loop_top.last
         && loop_top.rule == 3'(CC_NEVER)) |=> fetch_addr_o == $past(ret_top));

    // R12: overflow flag stays set until reset
    p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        stk_ovf_o |=> stk_ovf_o);

    // R5: underflow flag stays set until reset
    p_unf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        stk_unf_o |=> stk_unf_o);

endmodule

// File: tb/lseq_top_tb_top.sv
module lseq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op = 3'd0;
    logic [2:0]  cond = 3'd0;
    logic [13:0] target = '0;
    logic [13:0] count = '0;
    logic        zf = 1'b0;
    logic        nf = 1'b0;
    logic [13:0] fetch;
    logic        ovf, unf;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int          t_used [16];
    logic [13:0] t_addr [16];
    logic [2:0]  t_op   [16];
    logic [2:0]  t_cond [16];
    logic [13:0] t_tgt  [16];
    logic [13:0] t_cnt  [16];

    always #5 clk = ~clk;

    lseq_top dut_i (
        .clk(clk), .rst(rst), .op_i(op), .cond_i(cond), .target_i(target),
        .count_i(count), .flag_zero_i(zf), .flag_neg_i(nf),
        .fetch_addr_o(fetch), .stk_ovf_o(ovf), .stk_unf_o(unf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_prog();
        for (int i = 0; i < 16; i++) t_used[i] = 0;
    endtask

    task automatic put(input int a, input int o, input int c, input int tg, input int n);
        for (int i = 0; i < 16; i++) begin
            if (t_used[i] == 0) begin
                t_used[i] = 1; t_addr[i] = 14'(a); t_op[i] = 3'(o);
                t_cond[i] = 3'(c); t_tgt[i] = 14'(tg); t_cnt[i] = 14'(n);
                return;
            end
        end
    endtask

    task automatic tick();
        op = 3'd0; cond = 3'd0; target = '0; count = '0;
        for (int i = 0; i < 16; i++) begin
            if (t_used[i] != 0 && t_addr[i] == fetch) begin
                op = t_op[i]; cond = t_cond[i]; target = t_tgt[i]; count = t_cnt[i];
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        clr_prog();
        zf = 0; nf = 0; op = 0; cond = 0;
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic bit exp_cc(input int c, input bit z, input bit n);
        case (c)
            0: return 1;
            1: return z;
            2: return !z;
            3: return n;
            4: return !n && !z;
            5: return !n;
            default: return 0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int p, v2, v4, guard, visits;
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk(fetch == 0, "R1 fetch", fetch, 0);
        chk(ovf == 0 && unf == 0, "R1 flags", {ovf, unf}, 0);

        // R2 sequential stepping
        for (int i = 1; i <= 3; i++) begin
            tick();
            chk(fetch == 14'(i), "R2 step", fetch, i);
        end

        // R3 sweep of every condition code and flag pair
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 4; f++) begin
                clr_prog();
                p = int'(fetch);
                put(p, 1, c, (p + 100) % 16384, 0);
                zf = f[0]; nf = f[1];
                tick();
                chk(int'(fetch) == (exp_cc(c, f[0], f[1]) ? (p + 100) % 16384 : (p + 1) % 16384),
                    "R3 jump", fetch, exp_cc(c, f[0], f[1]) ? (p + 100) % 16384 : (p + 1) % 16384);
            end
        end
        zf = 0; nf = 0;

        // R2 wrap at top of address space
        clr_prog();
        put(int'(fetch), 1, 0, 16383, 0);
        tick();
        tick();
        chk(fetch == 0, "R2 wrap", fetch, 0);

        // R4 R5 call and return
        do_reset();
        put(0, 2, 0, 200, 0);
        put(200, 2, 0, 300, 0);
        put(300, 3, 0, 0, 0);
        put(201, 3, 0, 0, 0);
        tick(); chk(fetch == 200, "R4 call", fetch, 200);
        tick(); chk(fetch == 300, "R4 nested call", fetch, 300);
        tick(); chk(fetch == 201, "R5 return", fetch, 201);
        tick(); chk(fetch == 1, "R5 outer return", fetch, 1);
        chk(unf == 0, "R5 no underflow", unf, 0);

        // R4 failed call pushes nothing; R5 return on empty stack
        do_reset();
        put(0, 2, 6, 500, 0);
        put(1, 3, 0, 0, 0);
        tick(); chk(fetch == 1, "R4 failed call", fetch, 1);
        tick(); chk(fetch == 2, "R5 empty return", fetch, 2);
        chk(unf == 1, "R5 underflow", unf, 1);

        // R6 R7 R8 counted loops, body at 1..3
        for (int n = 1; n <= 4; n++) begin
            do_reset();
            put(0, 4, 7, 3, n);
            put(4, 3, 0, 0, 0);
            tick();
            for (int pass = 0; pass < n; pass++) begin
                for (int k = 1; k <= 3; k++) begin
                    chk(fetch == 14'(k), "R7 loop body", fetch, k);
                    tick();
                end
            end
            chk(fetch == 4, "R8 loop exit", fetch, 4);
            tick();
            chk(unf == 1 && fetch == 5, "R8 stacks popped", {unf, fetch}, 5 + 16384);
        end

        // R10 nested counted loops: outer 2 passes over 1..5, inner 3 passes over 2..3
        do_reset();
        put(0, 4, 7, 5, 2);
        put(1, 4, 7, 3, 3);
        v2 = 0; v4 = 0; guard = 0;
        tick();
        while (fetch != 6 && guard < 200) begin
            if (fetch == 2) v2++;
            if (fetch == 4) v4++;
            tick();
            guard++;
        end
        chk(fetch == 6, "R10 nested exit", fetch, 6);
        chk(v2 == 6, "R10 inner passes", v2, 6);
        chk(v4 == 2, "R10 outer passes", v4, 2);
        chk(ovf == 0 && unf == 0, "R10 clean stacks", {ovf, unf}, 0);

        // R9 condition-terminated loop exits on the third pass
        do_reset();
        put(0, 4, 1, 2, 0);
        visits = 0; guard = 0;
        tick();
        while (fetch != 3 && guard < 100) begin
            if (fetch == 2) begin
                visits++;
                zf = (visits == 3);
            end else begin
                zf = 0;
            end
            tick();
            guard++;
        end
        zf = 0;
        chk(fetch == 3, "R9 exit addr", fetch, 3);
        chk(visits == 3, "R9 passes", visits, 3);

        // R11 taken jump at the last address wins over loop-back
        do_reset();
        put(0, 4, 7, 2, 3);
        put(2, 1, 0, 50, 0);
        tick(); tick(); tick();
        chk(fetch == 50, "R11 branch priority", fetch, 50);

        // R12 return stack overflow: 17 calls, 17th push dropped
        do_reset();
        for (int i = 0; i < 17; i++) begin
            clr_prog();
            put(int'(fetch), 2, 0, int'(fetch) + 1, 0);
            tick();
            if (i == 15) chk(ovf == 0, "R12 16 calls fit", ovf, 0);
        end
        chk(ovf == 1, "R12 return overflow", ovf, 1);
        clr_prog();
        put(17, 3, 0, 0, 0);
        tick();
        chk(fetch == 16, "R12 dropped push", fetch, 16);
        for (int i = 0; i < 15; i++) begin
            clr_prog();
            put(int'(fetch), 3, 0, 0, 0);
            tick();
        end
        chk(unf == 0, "R5 no early underflow", unf, 0);
        clr_prog();
        p = int'(fetch);
        put(p, 3, 0, 0, 0);
        tick();
        chk(unf == 1 && int'(fetch) == p + 1, "R5 underflow after drain", {unf, fetch}, 16384 + p + 1);

        // R12 loop stack overflow at the fifth nested loop
        do_reset();
        for (int i = 0; i < 5; i++) begin
            clr_prog();
            put(int'(fetch), 4, 6, 100, 0);
            tick();
            if (i == 3) chk(ovf == 0, "R12 4 loops fit", ovf, 0);
        end
        chk(ovf == 1, "R12 loop overflow", ovf, 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule